// File: doc/BRIEF.md
# Shared Buffer Memory Request Arbiter

This block decides, once per clock, which of four requesters may make the next access to a shared buffer memory. The four requesters are the microcontroller port, the host DMA port and two internal data-path channels, called A and B. The microcontroller is always served first. Channel A ranks above channel B.

The host port has a run-time priority setting held in a one-bit configuration register. When the setting is clear, which is its reset value, the host ranks lowest of all four. When it is set, the host ranks directly below the microcontroller and above both channels. Software changes the setting with a single-cycle write strobe.

The decision is held in a small state register whose state names the requester currently being served. The state register is reloaded on every edge, so each grant covers exactly one access. The outputs are a one-hot grant vector, a busy flag and a binary index of the winner.

Requester index encoding, used for `req`, `gnt` and `gnt_id`: 0 = microcontroller, 1 = host, 2 = channel A, 3 = channel B.

States:
- SRV_IDLE: nothing granted.
- SRV_MCU, SRV_HOST, SRV_CHA, SRV_CHB: the named requester holds the grant for this cycle.

Transitions: from every state, on each edge, the next state is chosen by priority.
- Any microcontroller request leads to SRV_MCU.
- Otherwise, a host request with the promotion bit set leads to SRV_HOST.
- Otherwise, a channel A request leads to SRV_CHA.
- Otherwise, a channel B request leads to SRV_CHB.
- Otherwise, a host request (promotion bit clear) leads to SRV_HOST.
- With no request at all, the next state is SRV_IDLE.

Reset forces SRV_IDLE.

Top module: `bufmem_arbiter`

## Requirements
- R1: A request on index 0 (microcontroller) is granted in the cycle after it is sampled, whatever the other requests and the promotion bit.
- R2: With the promotion bit at 1 and no index-0 request, a host request (index 1) is granted over channels A and B.
- R3: With the promotion bit at 0, the host (index 1) is granted only when no other requester is requesting.
- R4: After reset the promotion bit is 0, the state is SRV_IDLE, `gnt` is 0 and `busy` is 0.
- R5: Channel A (index 2) is granted over channel B (index 3) when neither the microcontroller nor a promoted host is requesting.
- R6: `gnt` is one-hot or zero. It reflects the requests sampled at the previous edge and is decided afresh on every edge, so each grant lasts exactly one cycle.
- R7: When no request is sampled at an edge, `gnt` and `busy` are 0 in the following cycle.
- R8: A write with `prio_wr`=1 loads `prio_wdata` into the promotion bit at that edge. The new value governs the decision made at the next edge, and the decision at the write edge uses the old value.
- R9: `busy` is 1 exactly when a grant is asserted, and `gnt_id` then holds the binary index of the granted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Request vector, one bit per requester index |
| prio_wr | input | 1 | Write strobe for the host promotion bit |
| prio_wdata | input | 1 | Value to write into the promotion bit |
| gnt | output | 4 | One-hot grant vector |
| busy | output | 1 | A grant is asserted this cycle |
| gnt_id | output | 2 | Index of the granted requester |

## Verification
Every grant is due one edge after the requests that produced it. A promotion-bit write takes effect at the decision one edge later, which puts its effect on `gnt` two edges after the write strobe.

The bench keeps a behavioural model that, at each rising edge, computes the expected grant from the present request vector and its own copy of the promotion bit, and only then applies any write. At the following falling edge, all three outputs are compared against the model before new stimulus is driven. This alignment covers both latencies without special cases.

Directed phases cover the reset state, each priority ordering with the promotion bit both clear and set, idle gaps, and writes on the same edge as contested requests. A long pseudo-random phase then follows.

// File: rtl/bufmem_arb_pkg.sv
package bufmem_arb_pkg;
    localparam int unsigned NREQ   = 4;
    localparam int unsigned IDW    = $clog2(NREQ);
    localparam int unsigned IX_MCU  = 0;
    localparam int unsigned IX_HOST = 1;
    localparam int unsigned IX_CHA  = 2;
    localparam int unsigned IX_CHB  = 3;

    typedef enum logic [2:0] {
        SRV_IDLE = 3'd0,
        SRV_MCU  = 3'd1,
        SRV_HOST = 3'd2,
        SRV_CHA  = 3'd3,
        SRV_CHB  = 3'd4
    } srv_state_t;
endpackage

// File: rtl/bufmem_arb_cfg.sv
module bufmem_arb_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_data,
    output logic host_hi
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_hi <= 1'b0;
        else if (wr_en)
            host_hi <= wr_data;
    end

    // R4: the promotion bit holds its reset value of zero on the first cycle after reset
    a_r4_cfg_reset_zero: assert property (@(posedge clk)
        $rose(rst_n) |-> !host_hi);

    // R8: with no write strobe, the bit keeps its value
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) && $past(rst_n) |-> $stable(host_hi));
endmodule

// File: rtl/bufmem_arb_pick.sv
module bufmem_arb_pick
    import bufmem_arb_pkg::*;
(
    input  logic [NREQ-1:0] req,
    input  logic            host_hi,
    output srv_state_t      pick
);
    always_comb begin
        pick = SRV_IDLE;
        if (req[IX_MCU])
            pick = SRV_MCU;
        else if (host_hi && req[IX_HOST])
            pick = SRV_HOST;
        else if (req[IX_CHA])
            pick = SRV_CHA;
        else if (req[IX_CHB])
            pick = SRV_CHB;
        else if (req[IX_HOST])
            pick = SRV_HOST;
    end
endmodule

// File: rtl/bufmem_arbiter.sv
module bufmem_arbiter
    import bufmem_arb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req,
    input  logic            prio_wr,
    input  logic            prio_wdata,
    output logic [NREQ-1:0] gnt,
    output logic            busy,
    output logic [IDW-1:0]  gnt_id
);
    logic       host_hi_q;
    srv_state_t state_q;
    srv_state_t state_d;

    bufmem_arb_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prio_wr),
        .wr_data (prio_wdata),
        .host_hi (host_hi_q)
    );

    bufmem_arb_pick u_pick (
        .req     (req),
        .host_hi (host_hi_q),
        .pick    (state_d)
    );

    // state register: a fresh decision on every edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SRV_IDLE;
        else
            state_q <= state_d;
    end

    // outputs decoded from the serving state
    always_comb begin
        gnt    = '0;
        gnt_id = '0;
        busy   = 1'b0;
        unique case (state_q)
            SRV_IDLE: ;
            SRV_MCU:  begin gnt[IX_MCU]  = 1'b1; gnt_id = IDW'(IX_MCU);  busy = 1'b1; end
            SRV_HOST: begin gnt[IX_HOST] = 1'b1; gnt_id = IDW'(IX_HOST); busy = 1'b1; end
            SRV_CHA:  begin gnt[IX_CHA]  = 1'b1; gnt_id = IDW'(IX_CHA);  busy = 1'b1; end
            SRV_CHB:  begin gnt[IX_CHB]  = 1'b1; gnt_id = IDW'(IX_CHB);  busy = 1'b1; end
            default: ;
        endcase
    end

    // R1: the microcontroller is served on the cycle after its request
    a_r1_mcu_first: assert property (@(posedge clk) disable iff (!rst_n)
        req[IX_MCU] |=> gnt[IX_MCU]);

    // R2: a promoted host beats both channels
    a_r2_host_promoted: assert property (@(posedge clk) disable iff (!rst_n)
        host_hi_q && req[IX_HOST] && !req[IX_MCU] |=> gnt[IX_HOST]);

    // R3: a demoted host is served only when nobody else asks
    a_r3_host_last: assert property (@(posedge clk) disable iff (!rst_n)
        !host_hi_q && req[IX_HOST] && (req[IX_MCU] || req[IX_CHA] || req[IX_CHB])
        |=> !gnt[IX_HOST]);

    // R5: channel A beats channel B
    a_r5_cha_over_chb: assert property (@(posedge clk) disable iff (!rst_n)
        req[IX_CHA] |=> !gnt[IX_CHB]);

    // R6: at most one grant at a time
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R7: no request sampled, nothing granted next cycle
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req == '0 |=> gnt == '0 && !busy);

    // R9: busy tracks the grant vector and the index matches
    a_r9_busy_id: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (gnt != '0) && (!busy || gnt[gnt_id]));
endmodule

// File: tb/bufmem_arbiter_bench.sv
module bufmem_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic       prio_wr = 1'b0;
    logic       prio_wdata = 1'b0;
    logic [3:0] gnt;
    logic       busy;
    logic [1:0] gnt_id;

    int n_vec = 0;
    int n_bad = 0;
    int exp_id = -1;
    bit model_hi = 0;
    int cyc = 0;
    string tag = "R4";

    always #5 clk = ~clk;

    bufmem_arbiter u_bufmem_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .prio_wr(prio_wr),
        .prio_wdata(prio_wdata), .gnt(gnt), .busy(busy), .gnt_id(gnt_id)
    );

    // behavioural reference: ordered list of candidates per setting
    always @(posedge clk) begin
        int order[$];
        cyc++;
        if (!rst_n) begin
            exp_id = -1;
            model_hi = 0;
        end else begin
            if (model_hi) order = '{0, 1, 2, 3};
            else          order = '{0, 2, 3, 1};
            exp_id = -1;
            foreach (order[k])
                if (exp_id < 0 && req[order[k]]) exp_id = order[k];
            if (prio_wr) model_hi = prio_wdata;
        end
    end

    task automatic check_out();
        logic [3:0] eg;
        eg = (exp_id < 0) ? 4'b0 : 4'(1 << exp_id);
        n_vec++;
        if (gnt !== eg || busy !== (exp_id >= 0) ||
            (exp_id >= 0 && gnt_id !== 2'(exp_id))) begin
            n_bad++;
            $display("FAIL %s R6 R9: gnt=%b busy=%b id=%0d expected gnt=%b busy=%0d id=%0d",
                     tag, gnt, busy, gnt_id, eg, exp_id >= 0, exp_id);
        end
    endtask

    task automatic step(input logic [3:0] r, input logic w, input logic wd);
        @(negedge clk);
        check_out();
        req = r; prio_wr = w; prio_wdata = wd;
    endtask

    initial begin
        logic [15:0] lf = 16'hACE1;
        repeat (3) @(negedge clk);
        check_out();                       // R4 state held in reset
        rst_n = 1'b1;
        tag = "R4";  step(4'b0000, 0, 0); step(4'b0000, 0, 0);
        tag = "R3";  step(4'b1110, 0, 0); step(4'b0010, 0, 0); step(4'b0110, 0, 0);
        tag = "R1";  step(4'b1111, 0, 0); step(4'b0001, 0, 0);
        tag = "R5";  step(4'b1100, 0, 0); step(4'b1000, 0, 0);
        tag = "R7";  step(4'b0000, 0, 0); step(4'b0000, 0, 0);
        tag = "R8";  step(4'b1110, 1, 1); step(4'b1110, 0, 0); step(4'b1110, 0, 0);
        tag = "R2";  step(4'b1010, 0, 0); step(4'b0110, 0, 0); step(4'b0011, 0, 0);
        tag = "R8";  step(4'b0110, 1, 0); step(4'b0110, 0, 0); step(4'b0110, 0, 0);
        tag = "R6";  step(4'b0100, 0, 0); step(4'b0000, 0, 0); step(4'b1000, 0, 0);
        tag = "RND";
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[3:0], lf[7:5] == 3'b000, lf[9]);
        end
        step(4'b0000, 0, 0);
        step(4'b0000, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog R6: actual hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule